// File: doc/BRIEF.md
# Mixed-Width Register Exchange Unit

This block holds a small processor register file made of eight 8-bit registers and eight 16-bit registers and carries out the register exchange operation on it. A one-byte operand selector names two registers; one strobe swaps them in a single clock, and a done pulse follows on the next cycle. The two registers may have the same width or different widths. When the widths differ, the byte register and the word register trade values under fixed byte-lane rules. Two of the byte slots form a constant-zero register that always reads zero.

The condition-code byte register is snapshotted when an exchange starts. The snapshot is driven out, and by default it is written back at the end of the operation, so an exchange never alters the condition codes. The register file is loaded and observed through plain write and read ports. Those ports stand in for the rest of the datapath.

Top module: `xchg_unit`

## Requirements
- R1: Selector bits 7:4 name the first operand and bits 3:0 name the second. In each nibble, bit 3 set selects a byte register and bit 3 clear selects a word register. Bits 2:0 give the register index, 0 to 7.
- R2: When both nibbles select word registers, the two word registers trade their full 16-bit values. Naming the same index twice leaves it unchanged.
- R3: When both nibbles select byte registers, the two byte registers trade values. Byte indices are 0 = A, 1 = B, 2 = CC, 3 = DP, 4 and 5 = zero, 6 = E, 7 = F.
- R4: In a mixed-width exchange with a non-zero byte register, the word register receives the byte register's old value in both its upper and lower byte. This holds whichever nibble names the byte register.
- R5: In a mixed-width exchange, byte registers 0 (A), 3 (DP) and 6 (E) receive the upper byte of the word register's old value. Byte registers 1 (B), 2 (CC) and 7 (F) receive its lower byte.
- R6: Byte indices 4 and 5 always read zero. A mixed exchange with them clears the word register and changes nothing else. A byte exchange with them writes zero into the other register. Port writes to them are dropped.
- R7: The CC value (byte index 2) seen at the start edge appears on `cc_save_o` from the done cycle onward. With the default setting, CC holds its value across every exchange, while its partner is still updated by R3 to R5.
- R8: `done_o` is high in exactly the cycle after each start strobe and low otherwise. The register results are visible in that same cycle.
- R9: With no start and no write, the registers hold their values. Port writes take effect at the next edge. A write presented in a start cycle is dropped.
- R10: Reset clears every register, `done_o` and `cc_save_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Exchange strobe |
| sel_i | input | 8 | Operand selector byte |
| done_o | output | 1 | Exchange completed pulse |
| cc_save_o | output | 8 | CC value captured at the last start |
| wr8_en_i | input | 1 | Byte register write enable |
| wr8_idx_i | input | 3 | Byte register write index |
| wr8_data_i | input | 8 | Byte register write data |
| wr16_en_i | input | 1 | Word register write enable |
| wr16_idx_i | input | 3 | Word register write index |
| wr16_data_i | input | 16 | Word register write data |
| rd8_idx_i | input | 3 | Byte register read index |
| rd8_data_o | output | 8 | Byte register read data |
| rd16_idx_i | input | 3 | Word register read index |
| rd16_data_o | output | 16 | Word register read data |

## Verification
Every register is preloaded with distinct values whose upper and lower bytes differ. Because of that, a swap, a lane pick and a byte duplication each give a different result. Selectors cover word-word pairs, byte-byte pairs, and mixed pairs with the byte register in either nibble. The mixed pairs use upper-lane and lower-lane byte registers, so a lane or ordering mistake shows up. Zero-slot, CC and same-index selectors separate the special cases from the plain swap. Directed steps cover the done pulse, a write that collides with a start, and reset.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    localparam int XIDX_W = 3;
    localparam int XNREG  = 1 << XIDX_W;
    localparam int XBYTE  = 8;
    localparam int XWORD  = 2 * XBYTE;

    typedef enum logic [1:0] {
        XK_NONE = 2'd0,
        XK_BYTE = 2'd1,
        XK_WORD = 2'd2,
        XK_MIX  = 2'd3
    } xkind_e;

    // For XK_MIX, a is always the byte register and b the word register.
    typedef struct packed {
        xkind_e              kind;
        logic [XIDX_W-1:0]   a;
        logic [XIDX_W-1:0]   b;
    } xop_t;
endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
    import xchg_pkg::*;
(
    input  logic [2*(XIDX_W+1)-1:0] sel_i,
    output xop_t                    op_o
);
    localparam int NIB = XIDX_W + 1;

    logic [NIB-1:0] first_n, second_n;
    logic           first_byte, second_byte;

    assign first_n     = sel_i[2*NIB-1:NIB];
    assign second_n    = sel_i[NIB-1:0];
    assign first_byte  = first_n[NIB-1];
    assign second_byte = second_n[NIB-1];

    always_comb begin
        op_o = '0;
        if (first_byte == second_byte) begin
            op_o.kind = first_byte ? XK_BYTE : XK_WORD;
            op_o.a    = first_n[XIDX_W-1:0];
            op_o.b    = second_n[XIDX_W-1:0];
        end else begin
            op_o.kind = XK_MIX;
            // canonical order: byte register first, word register second
            if (second_byte) begin
                op_o.a = second_n[XIDX_W-1:0];
                op_o.b = first_n[XIDX_W-1:0];
            end else begin
                op_o.a = first_n[XIDX_W-1:0];
                op_o.b = second_n[XIDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/xchg_lane.sv
module xchg_lane
    import xchg_pkg::*;
#(
    parameter logic [XNREG-1:0] HI_MASK   = 8'b0100_1001,
    parameter logic [XNREG-1:0] ZERO_MASK = 8'b0011_0000
) (
    input  logic [XIDX_W-1:0] byte_idx_i,
    input  logic [XWORD-1:0]  word_i,
    output logic [XBYTE-1:0]  lane_o,
    output logic              zero_o
);
    assign lane_o = HI_MASK[byte_idx_i] ? word_i[XWORD-1:XBYTE] : word_i[XBYTE-1:0];
    assign zero_o = ZERO_MASK[byte_idx_i];
endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
    import xchg_pkg::*;
#(
    parameter logic [XNREG-1:0] HI_MASK   = 8'b0100_1001,
    parameter logic [XNREG-1:0] ZERO_MASK = 8'b0011_0000,
    parameter int               CC_IDX    = 2,
    parameter bit               KEEP_CC   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        sel_i,
    output logic              done_o,
    output logic [XBYTE-1:0]  cc_save_o,
    input  logic              wr8_en_i,
    input  logic [XIDX_W-1:0] wr8_idx_i,
    input  logic [XBYTE-1:0]  wr8_data_i,
    input  logic              wr16_en_i,
    input  logic [XIDX_W-1:0] wr16_idx_i,
    input  logic [XWORD-1:0]  wr16_data_i,
    input  logic [XIDX_W-1:0] rd8_idx_i,
    output logic [XBYTE-1:0]  rd8_data_o,
    input  logic [XIDX_W-1:0] rd16_idx_i,
    output logic [XWORD-1:0]  rd16_data_o
);
    typedef struct packed {
        logic [XNREG-1:0][XBYTE-1:0] r8;
        logic [XNREG-1:0][XWORD-1:0] r16;
        logic                        done;
        logic [XBYTE-1:0]            cc_save;
    } st_t;

    st_t  st_d, st_q;
    xop_t op;
    logic [XBYTE-1:0] lane_byte;
    logic             lane_zero;
    logic             cc_keep;

    xchg_decode u_decode (
        .sel_i (sel_i),
        .op_o  (op)
    );

    xchg_lane #(
        .HI_MASK   (HI_MASK),
        .ZERO_MASK (ZERO_MASK)
    ) u_lane (
        .byte_idx_i (op.a),
        .word_i     (st_q.r16[op.b]),
        .lane_o     (lane_byte),
        .zero_o     (lane_zero)
    );

    generate
        if (KEEP_CC) begin : g_cc_keep
            assign cc_keep = 1'b1;
        end else begin : g_cc_free
            assign cc_keep = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.cc_save = st_q.r8[CC_IDX];
            // every read below comes from st_q, so the swap is atomic
            unique case (op.kind)
                XK_WORD: begin
                    st_d.r16[op.a] = st_q.r16[op.b];
                    st_d.r16[op.b] = st_q.r16[op.a];
                end
                XK_BYTE: begin
                    st_d.r8[op.a] = st_q.r8[op.b];
                    st_d.r8[op.b] = st_q.r8[op.a];
                end
                XK_MIX: begin
                    if (lane_zero) begin
                        st_d.r16[op.b] = '0;
                    end else begin
                        st_d.r8[op.a]  = lane_byte;
                        st_d.r16[op.b] = {2{st_q.r8[op.a]}};
                    end
                end
                default: ;
            endcase
            if (cc_keep) begin
                st_d.r8[CC_IDX] = st_d.cc_save;
            end
        end else begin
            if (wr8_en_i) begin
                st_d.r8[wr8_idx_i] = wr8_data_i;
            end
            if (wr16_en_i) begin
                st_d.r16[wr16_idx_i] = wr16_data_i;
            end
        end
        for (int i = 0; i < XNREG; i++) begin
            if (ZERO_MASK[i]) begin
                st_d.r8[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign cc_save_o   = st_q.cc_save;
    assign rd8_data_o  = st_q.r8[rd8_idx_i];
    assign rd16_data_o = st_q.r16[rd16_idx_i];

    // R8: one done pulse for each start, in the following cycle
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R9: no activity leaves the file untouched
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !wr8_en_i && !wr16_en_i) |=> ($stable(st_q.r8) && $stable(st_q.r16)));

    // R2: word-word exchange moves the second operand into the first
    p_word_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op.kind == XK_WORD) |=> (st_q.r16[$past(op.a)] == $past(st_q.r16[op.b])));

    // R4: mixed exchange duplicates the byte into the word register
    p_mix_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op.kind == XK_MIX && !lane_zero)
            |=> (st_q.r16[$past(op.b)] == {2{$past(st_q.r8[op.a])}}));

    // R6: zero slots always read zero
    p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ZERO_MASK[rd8_idx_i] |-> (rd8_data_o == '0));

    // R7: condition codes survive an exchange when kept
    p_cc_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cc_keep) |=> (st_q.r8[CC_IDX] == $past(st_q.r8[CC_IDX])));
endmodule

// File: tb/xchg_unit_bench.sv
module xchg_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  sel_i = '0;
    logic        done_o;
    logic [7:0]  cc_save_o;
    logic        wr8_en_i = 1'b0;
    logic [2:0]  wr8_idx_i = '0;
    logic [7:0]  wr8_data_i = '0;
    logic        wr16_en_i = 1'b0;
    logic [2:0]  wr16_idx_i = '0;
    logic [15:0] wr16_data_i = '0;
    logic [2:0]  rd8_idx_i = '0;
    logic [7:0]  rd8_data_o;
    logic [2:0]  rd16_idx_i = '0;
    logic [15:0] rd16_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xchg_unit u_xchg_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .done_o(done_o), .cc_save_o(cc_save_o),
        .wr8_en_i(wr8_en_i), .wr8_idx_i(wr8_idx_i), .wr8_data_i(wr8_data_i),
        .wr16_en_i(wr16_en_i), .wr16_idx_i(wr16_idx_i), .wr16_data_i(wr16_data_i),
        .rd8_idx_i(rd8_idx_i), .rd8_data_o(rd8_data_o),
        .rd16_idx_i(rd16_idx_i), .rd16_data_o(rd16_data_o)
    );

    // {selector, byte?, idx, expected, byte?, idx, expected, requirement}
    localparam int NV = 16;
    localparam logic [51:0] VEC [NV] = '{
        {8'h12, 1'b0, 3'd1, 16'hA2C2, 1'b0, 3'd2, 16'hA1C1, 4'd2},  // R2 word swap
        {8'h77, 1'b0, 3'd7, 16'hA7C7, 1'b0, 3'd6, 16'hA6C6, 4'd2},  // R2 same index
        {8'h89, 1'b1, 3'd0, 16'h0022, 1'b1, 3'd1, 16'h0011, 4'd3},  // R3 A<->B
        {8'hE8, 1'b1, 3'd6, 16'h0011, 1'b1, 3'd0, 16'h0077, 4'd3},  // R3 E<->A
        {8'hF6, 1'b1, 3'd7, 16'h00C6, 1'b0, 3'd6, 16'h8888, 4'd5},  // R5 F low lane
        {8'h38, 1'b1, 3'd0, 16'h00A3, 1'b0, 3'd3, 16'h1111, 4'd1},  // R1 R4 byte in second nibble
        {8'hB5, 1'b1, 3'd3, 16'h00A5, 1'b0, 3'd5, 16'h4444, 4'd5},  // R5 DP high lane
        {8'h0E, 1'b1, 3'd6, 16'h00A0, 1'b0, 3'd0, 16'h7777, 4'd5},  // R5 E high lane
        {8'h49, 1'b1, 3'd1, 16'h00C4, 1'b0, 3'd4, 16'h2222, 4'd5},  // R5 B low lane
        {8'hC2, 1'b0, 3'd2, 16'h0000, 1'b1, 3'd4, 16'h0000, 4'd6},  // R6 zero clears word
        {8'h5D, 1'b0, 3'd5, 16'h0000, 1'b1, 3'd0, 16'h0011, 4'd6},  // R6 nothing else moves
        {8'h8C, 1'b1, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0000, 4'd6},  // R6 byte with zero
        {8'hA0, 1'b1, 3'd2, 16'h0033, 1'b0, 3'd0, 16'h3333, 4'd7},  // R7 CC kept, partner set
        {8'h9A, 1'b1, 3'd1, 16'h0033, 1'b1, 3'd2, 16'h0033, 4'd7},  // R7 B<->CC
        {8'h8D, 1'b1, 3'd0, 16'h0000, 1'b1, 3'd5, 16'h0000, 4'd6},  // R6 zero index 5
        {8'hFF, 1'b1, 3'd7, 16'h0088, 1'b1, 3'd6, 16'h0077, 4'd3}   // R3 same index
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp,
                       input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic rd(input bit is8, input logic [2:0] idx, output logic [15:0] v);
        rd8_idx_i  = idx;
        rd16_idx_i = idx;
        #0.5;
        v = is8 ? {8'h00, rd8_data_o} : rd16_data_o;
    endtask

    task automatic preload();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr8_en_i = 1'b1;  wr8_idx_i = 3'(i);  wr8_data_i = 8'(8'h11 * (i + 1));
            wr16_en_i = 1'b1; wr16_idx_i = 3'(i); wr16_data_i = {8'(8'hA0 + i), 8'(8'hC0 + i)};
        end
        @(negedge clk);
        wr8_en_i = 1'b0;
        wr16_en_i = 1'b0;
    endtask

    task automatic xchg(input logic [7:0] sel);
        @(negedge clk);
        start_i = 1'b1;
        sel_i   = sel;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        bit bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        bad = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd(1'b1, 3'(i), v); if (v != 0) bad = 1'b1;
            rd(1'b0, 3'(i), v); if (v != 0) bad = 1'b1;
        end
        chk("R10", {15'd0, bad}, 16'd0, "registers after reset");
        chk("R10", {15'd0, done_o}, 16'd0, "done after reset");
        chk("R10", {8'd0, cc_save_o}, 16'd0, "cc_save after reset");

        // table walk
        for (int n = 0; n < NV; n++) begin
            logic [51:0] e;
            string tag;
            e = VEC[n];
            tag = $sformatf("R%0d", e[3:0]);
            preload();
            xchg(e[51:44]);
            chk("R8", {15'd0, done_o}, 16'd1, $sformatf("done after selector %h", e[51:44]));
            rd(e[43], e[42:40], v);
            chk(tag, v, e[39:24], $sformatf("sel %h first check", e[51:44]));
            rd(e[23], e[22:20], v);
            chk(tag, v, e[19:4], $sformatf("sel %h second check", e[51:44]));
        end

        // R8: done lasts a single cycle
        @(negedge clk);
        chk("R8", {15'd0, done_o}, 16'd0, "done one cycle later");

        // R7: captured CC
        preload();
        xchg(8'hA0);
        chk("R7", {8'd0, cc_save_o}, 16'h0033, "cc_save after exchange");

        // R9: write during start is dropped
        preload();
        @(negedge clk);
        start_i = 1'b1; sel_i = 8'h23;
        wr16_en_i = 1'b1; wr16_idx_i = 3'd1; wr16_data_i = 16'hDEAD;
        @(negedge clk);
        start_i = 1'b0; wr16_en_i = 1'b0;
        rd(1'b0, 3'd1, v); chk("R9", v, 16'hA1C1, "write in start cycle");
        rd(1'b0, 3'd2, v); chk("R9", v, 16'hA3C3, "swap beside dropped write");

        // R9: idle hold and normal write
        repeat (5) @(negedge clk);
        rd(1'b0, 3'd3, v); chk("R9", v, 16'hA2C2, "idle hold");
        @(negedge clk);
        wr8_en_i = 1'b1; wr8_idx_i = 3'd7; wr8_data_i = 8'h5A;
        @(negedge clk);
        wr8_en_i = 1'b0;
        rd(1'b1, 3'd7, v); chk("R9", v, 16'h005A, "port write");

        // R6: port write to zero slot dropped
        @(negedge clk);
        wr8_en_i = 1'b1; wr8_idx_i = 3'd4; wr8_data_i = 8'hFF;
        @(negedge clk);
        wr8_en_i = 1'b0;
        rd(1'b1, 3'd4, v); chk("R6", v, 16'h0000, "write to zero slot");

        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, 3'd0, v); chk("R10", v, 16'h0000, "word after mid reset");
        rd(1'b1, 3'd1, v); chk("R10", v, 16'h0000, "byte after mid reset");

        finish_run();
    end
endmodule